// File: doc/BRIEF.md
# STM-1 Regenerator Section Receiver

This block sits directly behind the line interface of an STM-1 receiver. The line delivers one byte per clock together with a flag saying whether a line signal is present. The block finds the frame alignment word and keeps counters for the row and column of every byte. It removes the frame-synchronous scrambling from every byte except the alignment and trace bytes of the first row. It also checks the regenerator-section parity byte against the parity of the previous frame.

The block supervises the line in three ways: out-of-frame, loss-of-frame and loss-of-signal. While any of these defects is present, every byte sent downstream is replaced with all ones. Downstream logic receives the descrambled byte, its row and column, a strobe on the first byte of each frame, and a once-per-frame parity report that carries the number of failing bit positions.

Top module: `rsr_rx`

## Requirements
- R1: After reset, oofOut is 1, lofOut is 0, losOut is 0, b1Strobe is 0 and outByte is 0xFF.
- R2: The alignment word is three bytes of 0xF6 followed by three bytes of 0x28. While out of frame, the first occurrence anywhere in the stream realigns the counters, so that the next byte is row 0, column 6 (all indexes zero-based). Out-of-frame clears when a second consecutive word is found at the expected place (row 0, column 5). The output for the byte that follows it (the column 6 trace byte) is then the unsquelched byte, and oofOut is 0 for it.
- R3: Descrambling XORs each byte with a key drawn from a 1 + x^6 + x^7 generator. The generator is seeded to all ones at row 0, column 7 and advances by eight bits for every byte it descrambles, MSB first. The first two key bytes after seeding are 0xFE and 0x04.
- R4: The bytes at row 0, columns 0 to 6 (alignment and trace bytes) pass through unchanged and do not advance the generator.
- R5: Each output byte appears one clock after its input byte, together with its row and column. frameStartOut is high only for row 0, column 0.
- R6: The parity of the previous frame is the XOR of all its bytes as received, before descrambling. The descrambled byte at row 1, column 0 is compared with it. In that byte's output cycle, b1Strobe pulses once, and b1ErrCnt gives the number of differing bit positions (0 to 8).
- R7: No parity report is made while out of frame. After out-of-frame clears, the first report comes in the second frame that starts after the clearing.
- R8: Out-of-frame is declared when the word is wrong at the expected place in 4 consecutive frames. Three wrong frames followed by a correct one do not declare it. oofOut rises on the output of column 6 of the fourth wrong frame.
- R9: Loss-of-frame rises after out-of-frame has lasted 24 frame periods. It clears in the same cycle that out-of-frame clears.
- R10: losOut follows the inverted sigPresent with one clock of delay.
- R11: While oofOut, lofOut or losOut is high, outByte is 0xFF.
- R12: Parity checking goes on during loss of signal. A parity report that falls on a byte taken without signal still carries the correct count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxByte | input | 8 | Received line byte |
| sigPresent | input | 1 | Line signal detected |
| outByte | output | 8 | Descrambled byte, or all ones on a defect |
| outRow | output | $clog2(ROWS) | Row of outByte |
| outCol | output | $clog2(COLS) | Column of outByte |
| frameStartOut | output | 1 | outByte is row 0, column 0 |
| oofOut | output | 1 | Out-of-frame indication |
| lofOut | output | 1 | Loss-of-frame indication |
| losOut | output | 1 | Loss-of-signal indication |
| b1Strobe | output | 1 | Parity report valid |
| b1ErrCnt | output | 4 | Number of failing parity bits |

## Verification
The parity report and the loss-of-signal squelch can fall in the same cycle. This happens when the signal drops for exactly the parity byte of a frame whose parity byte was corrupted on purpose. The bench creates this by lowering sigPresent for that one byte only. It then checks, in that single output cycle, that the byte is all ones, that losOut is high and that the strobe carries the count of the corrupted bits. In the next cycle it checks that losOut is low and the data is back. Out-of-frame declaration and loss-of-frame timing are also exercised against exact frame positions, which the bench computes from the thresholds.

// File: rtl/rsr_pkg.sv
package rsr_pkg;
  typedef struct packed {
    logic frameStart;
    logic exempt;
    logic seedScr;
    logic b1Slot;
    logic aligned;
    logic squelch;
  } rsrCtlT;
endpackage

// File: rtl/rsr_ctrl.sv
module rsr_ctrl
  import rsr_pkg::*;
#(
  parameter int ROWS = 9,
  parameter int COLS = 270,
  parameter int NA1 = 3,
  parameter int NA2 = 3,
  parameter int OOF_SET = 4,
  parameter int OOF_CLR = 2,
  parameter int LOF_FRAMES = 24,
  parameter logic [7:0] A1_VAL = 8'hF6,
  parameter logic [7:0] A2_VAL = 8'h28
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [7:0]               rxByte,
  output rsrCtlT                   ctl,
  output logic [$clog2(ROWS)-1:0]  row,
  output logic [$clog2(COLS)-1:0]  col,
  output logic                     oof,
  output logic                     lof
);
  localparam int HDR = NA1 + NA2;
  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(COLS);
  localparam int FRAME_BYTES = ROWS * COLS;
  localparam int LOF_TICKS = LOF_FRAMES * FRAME_BYTES;
  localparam int LOF_W = $clog2(LOF_TICKS + 1);
  localparam int MISS_W = $clog2(OOF_SET + 1);
  localparam int GOOD_W = $clog2(OOF_CLR + 1);
  localparam int WIN_W = (HDR - 1) * 8;

  function automatic logic [HDR*8-1:0] mkPattern();
    logic [HDR*8-1:0] p;
    for (int i = 0; i < HDR; i++) begin
      p[(HDR-1-i)*8 +: 8] = (i < NA1) ? A1_VAL : A2_VAL;
    end
    return p;
  endfunction

  localparam logic [HDR*8-1:0] PATTERN = mkPattern();

  logic [WIN_W-1:0]  winQ;
  logic              patMatch;
  logic              atMark;
  logic              cand;
  logic [MISS_W-1:0] missCnt;
  logic [GOOD_W-1:0] goodCnt;
  logic [LOF_W-1:0]  lofCnt;

  assign patMatch = ({winQ, rxByte} == PATTERN);
  assign atMark   = (row == '0) && (col == COL_W'(HDR - 1));

  always_comb begin
    ctl.frameStart = (row == '0) && (col == '0);
    ctl.exempt     = (row == '0) && (col < COL_W'(HDR + 1));
    ctl.seedScr    = (row == '0) && (col == COL_W'(HDR + 1));
    ctl.b1Slot     = (row == ROW_W'(1)) && (col == '0);
    ctl.aligned    = !oof;
    ctl.squelch    = oof | lof;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winQ    <= '0;
      row     <= '0;
      col     <= '0;
      oof     <= 1'b1;
      cand    <= 1'b0;
      missCnt <= '0;
      goodCnt <= '0;
      lofCnt  <= '0;
      lof     <= 1'b0;
    end else begin
      winQ <= {winQ[WIN_W-9:0], rxByte};

      if (col == COL_W'(COLS - 1)) begin
        col <= '0;
        row <= (row == ROW_W'(ROWS - 1)) ? '0 : row + 1'b1;
      end else begin
        col <= col + 1'b1;
      end

      if (oof) begin
        if (lofCnt == LOF_W'(LOF_TICKS - 1)) lof <= 1'b1;
        else lofCnt <= lofCnt + 1'b1;

        if (!cand) begin
          if (patMatch) begin
            cand    <= 1'b1;
            goodCnt <= GOOD_W'(1);
            row     <= '0;
            col     <= COL_W'(HDR);
            if (OOF_CLR <= 1) begin
              oof    <= 1'b0;
              lof    <= 1'b0;
              lofCnt <= '0;
            end
          end
        end else if (atMark) begin
          if (patMatch) begin
            goodCnt <= goodCnt + 1'b1;
            if (int'(goodCnt) + 1 >= OOF_CLR) begin
              oof     <= 1'b0;
              cand    <= 1'b0;
              missCnt <= '0;
              lof     <= 1'b0;
              lofCnt  <= '0;
            end
          end else begin
            cand <= 1'b0;
          end
        end
      end else if (atMark) begin
        if (patMatch) begin
          missCnt <= '0;
        end else if (missCnt == MISS_W'(OOF_SET - 1)) begin
          oof     <= 1'b1;
          cand    <= 1'b0;
          missCnt <= '0;
        end else begin
          missCnt <= missCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rsr_datapath.sv
module rsr_datapath
  import rsr_pkg::*;
#(
  parameter int ROWS = 9,
  parameter int COLS = 270
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [7:0]               rxByte,
  input  logic                     sigPresent,
  input  rsrCtlT                   ctl,
  input  logic [$clog2(ROWS)-1:0]  row,
  input  logic [$clog2(COLS)-1:0]  col,
  input  logic                     oof,
  input  logic                     lof,
  output logic [7:0]               outByte,
  output logic [$clog2(ROWS)-1:0]  outRow,
  output logic [$clog2(COLS)-1:0]  outCol,
  output logic                     frameStartOut,
  output logic                     oofOut,
  output logic                     lofOut,
  output logic                     losOut,
  output logic                     b1Strobe,
  output logic [3:0]               b1ErrCnt
);
  function automatic logic [7:0] keyOf(input logic [6:0] s);
    logic [6:0] st;
    logic [7:0] k;
    st = s;
    for (int i = 7; i >= 0; i--) begin
      k[i] = st[6];
      st = {st[5:0], st[6] ^ st[5]};
    end
    return k;
  endfunction

  function automatic logic [6:0] stepOf(input logic [6:0] s);
    logic [6:0] st;
    st = s;
    for (int i = 0; i < 8; i++) st = {st[5:0], st[6] ^ st[5]};
    return st;
  endfunction

  function automatic logic [3:0] popCnt(input logic [7:0] v);
    logic [3:0] n;
    n = '0;
    for (int i = 0; i < 8; i++) n = n + {3'b000, v[i]};
    return n;
  endfunction

  logic [6:0] lfsr;
  logic [6:0] curSeed;
  logic [7:0] descr;
  logic [7:0] bipAcc;
  logic [7:0] bipPrev;
  logic       runOk;
  logic       prevOk;
  logic       squelchNow;

  assign curSeed    = ctl.seedScr ? 7'h7F : lfsr;
  assign descr      = ctl.exempt ? rxByte : (rxByte ^ keyOf(curSeed));
  assign squelchNow = ctl.squelch | !sigPresent;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsr          <= 7'h7F;
      bipAcc        <= '0;
      bipPrev       <= '0;
      runOk         <= 1'b0;
      prevOk        <= 1'b0;
      outByte       <= 8'hFF;
      outRow        <= '0;
      outCol        <= '0;
      frameStartOut <= 1'b0;
      oofOut        <= 1'b1;
      lofOut        <= 1'b0;
      losOut        <= 1'b0;
      b1Strobe      <= 1'b0;
      b1ErrCnt      <= '0;
    end else begin
      if (!ctl.exempt) lfsr <= stepOf(curSeed);

      if (ctl.frameStart) begin
        bipAcc  <= rxByte;
        bipPrev <= bipAcc;
        prevOk  <= runOk;
        runOk   <= ctl.aligned;
      end else begin
        bipAcc <= bipAcc ^ rxByte;
      end

      b1Strobe      <= ctl.b1Slot && prevOk && ctl.aligned;
      b1ErrCnt      <= popCnt(descr ^ bipPrev);
      outByte       <= squelchNow ? 8'hFF : descr;
      outRow        <= row;
      outCol        <= col;
      frameStartOut <= ctl.frameStart;
      oofOut        <= oof;
      lofOut        <= lof;
      losOut        <= !sigPresent;
    end
  end
endmodule

// File: rtl/rsr_rx.sv
module rsr_rx
  import rsr_pkg::*;
#(
  parameter int ROWS = 9,
  parameter int COLS = 270,
  parameter int NA1 = 3,
  parameter int NA2 = 3,
  parameter int OOF_SET = 4,
  parameter int OOF_CLR = 2,
  parameter int LOF_FRAMES = 24
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [7:0]               rxByte,
  input  logic                     sigPresent,
  output logic [7:0]               outByte,
  output logic [$clog2(ROWS)-1:0]  outRow,
  output logic [$clog2(COLS)-1:0]  outCol,
  output logic                     frameStartOut,
  output logic                     oofOut,
  output logic                     lofOut,
  output logic                     losOut,
  output logic                     b1Strobe,
  output logic [3:0]               b1ErrCnt
);
  rsrCtlT                   ctl;
  logic [$clog2(ROWS)-1:0]  row;
  logic [$clog2(COLS)-1:0]  col;
  logic                     oof;
  logic                     lof;

  rsr_ctrl #(
    .ROWS(ROWS), .COLS(COLS), .NA1(NA1), .NA2(NA2),
    .OOF_SET(OOF_SET), .OOF_CLR(OOF_CLR), .LOF_FRAMES(LOF_FRAMES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .rxByte(rxByte),
    .ctl(ctl), .row(row), .col(col), .oof(oof), .lof(lof)
  );

  rsr_datapath #(.ROWS(ROWS), .COLS(COLS)) uData (
    .clk(clk), .rstN(rstN), .rxByte(rxByte), .sigPresent(sigPresent),
    .ctl(ctl), .row(row), .col(col), .oof(oof), .lof(lof),
    .outByte(outByte), .outRow(outRow), .outCol(outCol),
    .frameStartOut(frameStartOut), .oofOut(oofOut), .lofOut(lofOut),
    .losOut(losOut), .b1Strobe(b1Strobe), .b1ErrCnt(b1ErrCnt)
  );
endmodule

// File: rtl/rsr_rx_chk.sv
module rsr_rx_chk #(
  parameter int ROWS = 9,
  parameter int COLS = 270
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [7:0]               outByte,
  input logic [$clog2(ROWS)-1:0]  outRow,
  input logic [$clog2(COLS)-1:0]  outCol,
  input logic                     frameStartOut,
  input logic                     oofOut,
  input logic                     lofOut,
  input logic                     losOut,
  input logic                     b1Strobe,
  input logic [3:0]               b1ErrCnt
);
  localparam int COL_W = $clog2(COLS);

  // R11
  squelch_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    (oofOut || lofOut || losOut) |-> (outByte == 8'hFF));

  // R9
  lof_implies_oof_chk: assert property (@(posedge clk) disable iff (!rstN)
    lofOut |-> oofOut);

  // R6
  b1_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    b1Strobe |-> (outRow == 1 && outCol == 0));

  // R6
  b1_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    b1Strobe |-> (b1ErrCnt <= 4'd8));

  // R5
  frame_start_pos_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStartOut |-> (outRow == 0 && outCol == 0));

  // R5
  col_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!oofOut && outCol != COL_W'(COLS - 1)) |=> (outCol == $past(outCol) + 1'b1));
endmodule

bind rsr_rx rsr_rx_chk #(.ROWS(ROWS), .COLS(COLS)) uChk (
  .clk(clk), .rstN(rstN), .outByte(outByte), .outRow(outRow), .outCol(outCol),
  .frameStartOut(frameStartOut), .oofOut(oofOut), .lofOut(lofOut),
  .losOut(losOut), .b1Strobe(b1Strobe), .b1ErrCnt(b1ErrCnt)
);

// File: tb/tb_rsr_rx.sv
module tb_rsr_rx;
  localparam int TROWS = 9;
  localparam int TCOLS = 30;
  localparam int FB = TROWS * TCOLS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic sigPresent = 1'b1;
  logic [7:0] outByte;
  logic [3:0] outRow;
  logic [4:0] outCol;
  logic frameStartOut, oofOut, lofOut, losOut, b1Strobe;
  logic [3:0] b1ErrCnt;

  int checks = 0;
  int failures = 0;

  logic [7:0] expP [FB];
  logic [7:0] obsB [FB];
  logic       obsO [FB];
  logic       obsL [FB];
  logic       obsLs[FB];
  logic       obsS [FB];
  logic       obsFs[FB];
  logic [3:0] obsC [FB];
  int         obsR [FB];
  int         obsK [FB];
  logic [7:0] txBip = 8'h00;

  always #10 clk = ~clk;

  rsr_rx #(.ROWS(TROWS), .COLS(TCOLS)) dut (
    .clk(clk), .rstN(rstN), .rxByte(rxByte), .sigPresent(sigPresent),
    .outByte(outByte), .outRow(outRow), .outCol(outCol),
    .frameStartOut(frameStartOut), .oofOut(oofOut), .lofOut(lofOut),
    .losOut(losOut), .b1Strobe(b1Strobe), .b1ErrCnt(b1ErrCnt)
  );

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_frame(input int seed, input logic [7:0] errMask,
                            input bit badA1, input int losIdx);
    logic [6:0] st;
    logic [7:0] nb;
    nb = 8'h00;
    st = 7'h7F;
    for (int i = 0; i < FB; i++) begin
      logic [7:0] p;
      logic [7:0] k;
      logic [7:0] raw;
      int r;
      int c;
      r = i / TCOLS;
      c = i % TCOLS;
      if (r == 0 && c < 3) p = (badA1 && c == 0) ? 8'h00 : 8'hF6;
      else if (r == 0 && c < 6) p = 8'h28;
      else if (r == 0 && c == 6) p = 8'h01;
      else if (r == 1 && c == 0) p = txBip ^ errMask;
      else p = 8'((seed * 37 + i * 11 + (i >> 3) * 5) & 255);
      expP[i] = p;
      if (r == 0 && c < 7) begin
        raw = p;
      end else begin
        if (r == 0 && c == 7) st = 7'h7F;
        for (int b = 7; b >= 0; b--) begin
          k[b] = st[6];
          st = {st[5:0], st[6] ^ st[5]};
        end
        raw = p ^ k;
      end
      nb = nb ^ raw;
      @(negedge clk);
      rxByte = raw;
      sigPresent = (i != losIdx);
      @(posedge clk);
      #2;
      obsB[i] = outByte;  obsO[i] = oofOut;  obsL[i] = lofOut;
      obsLs[i] = losOut;  obsS[i] = b1Strobe; obsC[i] = b1ErrCnt;
      obsFs[i] = frameStartOut; obsR[i] = int'(outRow); obsK[i] = int'(outCol);
    end
    txBip = nb;
  endtask

  function automatic int dataMism();
    int n;
    n = 0;
    for (int i = 0; i < FB; i++) if (obsB[i] != expP[i]) n++;
    return n;
  endfunction

  function automatic int strobeCount();
    int n;
    n = 0;
    for (int i = 0; i < FB; i++) if (obsS[i]) n++;
    return n;
  endfunction

  task automatic b1Frame(input int seed, input logic [7:0] mask, input int expCnt, input string tag);
    send_frame(seed, mask, 1'b0, -1);
    check({tag, " strobe count"}, strobeCount() == 1, strobeCount(), 1);
    check({tag, " strobe slot"}, obsS[TCOLS] == 1'b1, int'(obsS[TCOLS]), 1);
    check({tag, " error bits"}, int'(obsC[TCOLS]) == expCnt, int'(obsC[TCOLS]), expCnt);
    check({tag, " data"}, dataMism() == 0, dataMism(), 0);
  endtask

  initial begin
    #4000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int rc;
    int cc;
    int bad;
    repeat (3) @(posedge clk);
    #2;
    check("R1 oofOut", oofOut == 1'b1, int'(oofOut), 1);
    check("R1 lofOut", lofOut == 1'b0, int'(lofOut), 0);
    check("R1 losOut", losOut == 1'b0, int'(losOut), 0);
    check("R1 outByte", outByte == 8'hFF, int'(outByte), 255);
    check("R1 b1Strobe", b1Strobe == 1'b0, int'(b1Strobe), 0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      rxByte = 8'h00;
    end

    send_frame(1, 8'h00, 1'b0, -1);
    send_frame(2, 8'h00, 1'b0, -1);
    check("R2 still oof at mark", obsO[5] == 1'b1, int'(obsO[5]), 1);
    check("R2 squelched at mark", obsB[5] == 8'hFF, int'(obsB[5]), 255);
    check("R2 oof cleared", obsO[6] == 1'b0, int'(obsO[6]), 0);
    check("R2 trace byte out", obsB[6] == 8'h01, int'(obsB[6]), 1);

    send_frame(3, 8'h00, 1'b0, -1);
    check("R7 no report in first frame", strobeCount() == 0, strobeCount(), 0);
    check("R3 descrambled data", dataMism() == 0, dataMism(), 0);
    bad = 0;
    for (int i = 0; i < 7; i++) if (obsB[i] != expP[i]) bad++;
    check("R4 overhead row unchanged", bad == 0, bad, 0);
    bad = 0;
    for (int i = 0; i < FB; i++) begin
      rc = i / TCOLS;
      cc = i % TCOLS;
      if (obsR[i] != rc || obsK[i] != cc) bad++;
      if (obsFs[i] != (i == 0)) bad++;
    end
    check("R5 row col start", bad == 0, bad, 0);

    b1Frame(4, 8'h00, 0, "R6 clean");
    b1Frame(5, 8'h01, 1, "R6 one bit");
    b1Frame(6, 8'hFF, 8, "R6 all bits");
    b1Frame(7, 8'h5A, 4, "R6 four bits");
    b1Frame(8, 8'h00, 0, "R6 clean again");

    send_frame(9, 8'h80, 1'b0, TCOLS);
    check("R12 report during los", obsS[TCOLS] == 1'b1, int'(obsS[TCOLS]), 1);
    check("R12 count during los", obsC[TCOLS] == 4'd1, int'(obsC[TCOLS]), 1);
    check("R10 los raised", obsLs[TCOLS] == 1'b1, int'(obsLs[TCOLS]), 1);
    check("R11 los squelch", obsB[TCOLS] == 8'hFF, int'(obsB[TCOLS]), 255);
    check("R10 los dropped", obsLs[TCOLS+1] == 1'b0, int'(obsLs[TCOLS+1]), 0);
    check("R10 data back", obsB[TCOLS+1] == expP[TCOLS+1], int'(obsB[TCOLS+1]), int'(expP[TCOLS+1]));

    for (int f = 0; f < 3; f++) send_frame(10 + f, 8'h00, 1'b1, -1);
    bad = 0;
    for (int i = 0; i < FB; i++) if (obsO[i]) bad++;
    check("R8 three misses tolerated", bad == 0, bad, 0);
    check("R8 data during misses", dataMism() == 0, dataMism(), 0);
    send_frame(13, 8'h00, 1'b0, -1);
    for (int f = 0; f < 3; f++) send_frame(14 + f, 8'h00, 1'b1, -1);
    bad = 0;
    for (int i = 0; i < FB; i++) if (obsO[i]) bad++;
    check("R8 counter reset by good word", bad == 0, bad, 0);
    send_frame(17, 8'h00, 1'b1, -1);
    check("R8 oof before declare", obsO[5] == 1'b0, int'(obsO[5]), 0);
    check("R8 oof declared", obsO[6] == 1'b1, int'(obsO[6]), 1);
    check("R11 oof squelch", obsB[6] == 8'hFF, int'(obsB[6]), 255);

    for (int f = 1; f <= 24; f++) begin
      send_frame(18 + f, 8'h00, 1'b1, -1);
      if (f == 5) begin
        bad = 0;
        for (int i = 0; i < FB; i++) if (obsB[i] != 8'hFF) bad++;
        check("R11 whole frame squelched", bad == 0, bad, 0);
        check("R7 no report while oof", strobeCount() == 0, strobeCount(), 0);
      end
      if (f == 23) check("R9 lof not yet", obsL[100] == 1'b0, int'(obsL[100]), 0);
      if (f == 24) check("R9 lof raised", obsL[20] == 1'b1, int'(obsL[20]), 1);
    end

    send_frame(50, 8'h00, 1'b0, -1);
    check("R9 lof held during hunt", obsL[FB-1] == 1'b1, int'(obsL[FB-1]), 1);
    send_frame(51, 8'h00, 1'b0, -1);
    check("R2 relock oof at mark", obsO[5] == 1'b1, int'(obsO[5]), 1);
    check("R2 relock oof cleared", obsO[6] == 1'b0, int'(obsO[6]), 0);
    check("R9 lof cleared with oof", obsL[6] == 1'b0 && obsL[5] == 1'b1, int'(obsL[6]), 0);
    check("R2 relock data", obsB[6] == 8'h01, int'(obsB[6]), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule